// File: doc/BRIEF.md
# IEC958 Subframe Formatter

This block sits in the audio path of a display transmitter. It takes 32-bit audio words from a valid/ready stream and turns each word into the transmitter's own subframe layout. That layout puts 24 bits of audio in the low part of the word and three marker bits above it: a channel-status bit, a parity bit and a block-start flag. The block has two formats, chosen by `cfg_mode` (0 = PCM, 1 = pre-formatted).

In PCM format, the block fills in the three marker bits itself. It keeps a frame index that wraps every 192 frames and a channel counter that runs over the configured channel count. The channel-status bit is read from a 32-bit seed that can be loaded at any time. The channel number is patched into one nibble of that seed, so each channel carries its own number. In pre-formatted format, the incoming words already hold the status bits and a preamble code, and the block only moves them into place.

The flow is steered by a two-state machine around a single output register. In ST_EMPTY the register holds no word. In ST_FULL it holds one word that waits for `out_ready`. The transitions are:
- load: ST_EMPTY to ST_FULL when a word is taken.
- chain: ST_FULL to ST_FULL when the held word leaves and a new one is taken in the same cycle.
- stall: ST_FULL to ST_FULL while `out_ready` is low.
- drain: ST_FULL to ST_EMPTY when the held word leaves and no new word arrives.
- flush: any state to ST_EMPTY on `restart`.

Top module: `iec_subframe_fmt`

## Requirements
- R1: In PCM format, output bits 23..0 equal input bits 23..0. The top input byte is discarded. Output bits 31..29 and 25..24 are 0.
- R2: In PCM format, output bit 27 is the XOR of output bits 26..0, so bits 27..0 together have even parity.
- R3: In PCM format, output bit 26 of a word in frame i (i < 32) is seed bit i. Seed byte k sits at `seed_data[8k+7:8k]`, so this is bit i mod 8 of byte i/8. Frames 32 to 191 carry 0 in bit 26.
- R4: Frames 20 to 23 do not use the upper nibble of seed byte 2. They carry bits 0 to 3 of (channel index + 1), with channels counted from 0 in input order within a frame.
- R5: Output bit 28 is 1 in PCM format only for channel 0 of frame 0.
- R6: The frame index advances after every N accepted words, where N is the channel count, and wraps from 191 to 0.
- R7: In pre-formatted format, the output is the input shifted right by 4 places, with input bit 3 copied into output bit 28.
- R8: `cfg_mode` and `cfg_chans` are sampled only in a cycle where `restart` is high. That restart also sets the frame index and channel counter to 0 and drops any held output word. No input word is accepted in that cycle (`in_ready` is 0).
- R9: A `cfg_chans` value below 2 acts as 2, and a value above 8 acts as 8.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` stays constant and `in_ready` is 0. Words leave in input order, none dropped and none repeated.
- R11: After reset, `out_valid` is 0, `in_ready` is 1, the format is PCM, the count is 2 and the seed is 0. A word accepted at a clock edge is presented with `out_valid` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous restart; samples the configuration |
| cfg_mode | input | 1 | Format select: 0 = PCM, 1 = pre-formatted |
| cfg_chans | input | 4 | Channel count (clamped to 2..8) |
| seed_load | input | 1 | Load the channel-status seed |
| seed_data | input | 32 | Seed value; byte k sits in bits 8k+7..8k |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input audio word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Formatted subframe word |

## Verification
Every formatted word is due one clock after the edge that accepts it. The bench drives each word just after a falling edge and reads the output at the next falling edge, half a period after the register loads. `in_ready` is combinational from the state, `out_ready` and `restart`, so it is read in the same cycle the stimulus changes, before the next rising edge. A restart or a configuration change shows up only after the rising edge that samples it, so the bench checks the output register is empty, and that the first word carries the block-start flag, only after that edge. In PCM streams, the bench model tracks the frame index and channel counter on its own and steps them only when a word is actually taken.

// File: rtl/iec_fmt_pkg.sv
package iec_fmt_pkg;
    localparam int WORD_W      = 32;
    localparam int AUD_W       = 24;
    localparam int BIT_CS      = 26;
    localparam int BIT_PAR     = 27;
    localparam int BIT_BLK     = 28;
    localparam int PRE_SHIFT   = 4;
    localparam int PRE_BLK_SRC = 3;

    typedef enum logic {
        MODE_PCM = 1'b0,
        MODE_PRE = 1'b1
    } fmt_mode_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hold_state_t;
endpackage

// File: rtl/iec_frame_tracker.sv
module iec_frame_tracker #(
    parameter int FRAMES = 192,
    parameter int MAX_CH = 8,
    localparam int FRAME_W = $clog2(FRAMES),
    localparam int CH_W    = $clog2(MAX_CH),
    localparam int CNT_W   = $clog2(MAX_CH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               step,
    input  logic [CNT_W-1:0]   chan_count,
    output logic [FRAME_W-1:0] frame_idx,
    output logic [CH_W-1:0]    chan_idx,
    output logic               block_first
);
    logic [FRAME_W-1:0] frame_q;
    logic [CH_W-1:0]    chan_q;
    logic               last_ch;
    logic               last_frame;

    assign last_ch    = (CNT_W'(chan_q) == (chan_count - CNT_W'(1)));
    assign last_frame = (frame_q == FRAME_W'(FRAMES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            chan_q  <= '0;
        end else if (restart) begin
            frame_q <= '0;
            chan_q  <= '0;
        end else if (step) begin
            if (last_ch) begin
                chan_q  <= '0;
                frame_q <= last_frame ? '0 : frame_q + FRAME_W'(1);
            end else begin
                chan_q <= chan_q + CH_W'(1);
            end
        end
    end

    assign frame_idx   = frame_q;
    assign chan_idx    = chan_q;
    assign block_first = (frame_q == '0) && (chan_q == '0);
endmodule

// File: rtl/iec_cs_lookup.sv
module iec_cs_lookup #(
    parameter int SEED_BYTES = 4,
    parameter int FRAMES     = 192,
    parameter int MAX_CH     = 8,
    parameter int PATCH_BYTE = 2,
    localparam int SEED_BITS = SEED_BYTES * 8,
    localparam int SEL_W     = $clog2(SEED_BITS),
    localparam int FRAME_W   = $clog2(FRAMES),
    localparam int CH_W      = $clog2(MAX_CH),
    localparam int NUM_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seed_load,
    input  logic [SEED_BITS-1:0] seed_data,
    input  logic [FRAME_W-1:0]   frame_idx,
    input  logic [CH_W-1:0]      chan_idx,
    output logic                 cs_bit
);
    logic [SEED_BITS-1:0] seed_q;
    logic [SEED_BITS-1:0] patched;
    logic [NUM_W-1:0]     chan_num;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed_q <= '0;
        end else if (seed_load) begin
            seed_q <= seed_data;
        end
    end

    assign chan_num = NUM_W'(chan_idx) + NUM_W'(1);

    // One seed byte gets its upper nibble replaced by the channel number.
    for (genvar b = 0; b < SEED_BYTES; b++) begin : g_byte
        if (b == PATCH_BYTE) begin : g_patch
            assign patched[b*8 +: 8] = {chan_num, seed_q[b*8 +: 4]};
        end else begin : g_plain
            assign patched[b*8 +: 8] = seed_q[b*8 +: 8];
        end
    end

    assign cs_bit = (frame_idx < FRAME_W'(SEED_BITS)) ? patched[frame_idx[SEL_W-1:0]] : 1'b0;
endmodule

// File: rtl/iec_word_packer.sv
module iec_word_packer
    import iec_fmt_pkg::*;
(
    input  logic              pcm_mode,
    input  logic [WORD_W-1:0] in_word,
    input  logic              cs_bit,
    input  logic              blk,
    output logic [WORD_W-1:0] out_word
);
    always_comb begin
        out_word = '0;
        if (pcm_mode) begin
            out_word[AUD_W-1:0] = in_word[AUD_W-1:0];
            out_word[BIT_CS]    = cs_bit;
            out_word[BIT_BLK]   = blk;
            out_word[BIT_PAR]   = ^out_word[BIT_PAR-1:0];
        end else begin
            out_word          = in_word >> PRE_SHIFT;
            out_word[BIT_BLK] = in_word[PRE_BLK_SRC];
        end
    end
endmodule

// File: rtl/iec_subframe_fmt.sv
module iec_subframe_fmt
    import iec_fmt_pkg::*;
#(
    parameter int FRAMES     = 192,
    parameter int MAX_CH     = 8,
    parameter int MIN_CH     = 2,
    parameter int SEED_BYTES = 4,
    parameter int PATCH_BYTE = 2,
    localparam int SEED_BITS = SEED_BYTES * 8,
    localparam int CNT_W     = $clog2(MAX_CH + 1),
    localparam int FRAME_W   = $clog2(FRAMES),
    localparam int CH_W      = $clog2(MAX_CH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 cfg_mode,
    input  logic [CNT_W-1:0]     cfg_chans,
    input  logic                 seed_load,
    input  logic [SEED_BITS-1:0] seed_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WORD_W-1:0]    in_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [WORD_W-1:0]    out_data
);
    fmt_mode_t          mode_q;
    logic [CNT_W-1:0]   count_q;
    hold_state_t        state_q;
    hold_state_t        state_d;
    logic               accept;
    logic               pcm_active;
    logic [FRAME_W-1:0] frame_idx;
    logic [CH_W-1:0]    chan_idx;
    logic               block_first;
    logic               cs_bit;
    logic [WORD_W-1:0]  packed_word;
    logic [WORD_W-1:0]  data_q;

    function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] v);
        if (v < CNT_W'(MIN_CH))      return CNT_W'(MIN_CH);
        else if (v > CNT_W'(MAX_CH)) return CNT_W'(MAX_CH);
        else                         return v;
    endfunction

    // Configuration is sampled on restart only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MODE_PCM;
            count_q <= CNT_W'(MIN_CH);
        end else if (restart) begin
            mode_q  <= fmt_mode_t'(cfg_mode);
            count_q <= clamp_count(cfg_chans);
        end
    end

    assign pcm_active = (mode_q == MODE_PCM);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Next state and handshake outputs.
    always_comb begin
        state_d  = state_q;
        in_ready = 1'b0;
        if (restart) begin
            state_d = ST_EMPTY;                    // flush
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    in_ready = 1'b1;
                    if (in_valid) state_d = ST_FULL;   // load
                end
                ST_FULL: begin
                    in_ready = out_ready;              // chain or stall
                    if (out_ready && !in_valid) state_d = ST_EMPTY;  // drain
                end
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    assign accept    = in_valid && in_ready;
    assign out_valid = (state_q == ST_FULL);
    assign out_data  = data_q;

    iec_frame_tracker #(
        .FRAMES (FRAMES),
        .MAX_CH (MAX_CH)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .step        (accept),
        .chan_count  (count_q),
        .frame_idx   (frame_idx),
        .chan_idx    (chan_idx),
        .block_first (block_first)
    );

    iec_cs_lookup #(
        .SEED_BYTES (SEED_BYTES),
        .FRAMES     (FRAMES),
        .MAX_CH     (MAX_CH),
        .PATCH_BYTE (PATCH_BYTE)
    ) u_cs (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .seed_data (seed_data),
        .frame_idx (frame_idx),
        .chan_idx  (chan_idx),
        .cs_bit    (cs_bit)
    );

    iec_word_packer u_pack (
        .pcm_mode (pcm_active),
        .in_word  (in_data),
        .cs_bit   (cs_bit),
        .blk      (block_first),
        .out_word (packed_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      data_q <= '0;
        else if (accept) data_q <= packed_word;
    end
endmodule

// File: rtl/iec_subframe_fmt_chk.sv
module iec_subframe_fmt_chk #(
    parameter int FRAMES  = 192,
    parameter int FRAME_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               restart,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [31:0]        out_data,
    input logic               pcm_active,
    input logic [FRAME_W-1:0] frame_idx
);
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !restart |=> out_valid && $stable(out_data)); // R10
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R10
    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !out_valid); // R8
    AST_NO_TAKE_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !in_ready); // R8
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data[31:29] == 3'b000); // R1
    AST_PCM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && pcm_active |-> out_data[25:24] == 2'b00); // R1
    AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && pcm_active |-> (^out_data[27:0]) == 1'b0); // R2
    AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(frame_idx) < FRAMES); // R6
endmodule

bind iec_subframe_fmt iec_subframe_fmt_chk #(
    .FRAMES  (FRAMES),
    .FRAME_W (FRAME_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .pcm_active (pcm_active),
    .frame_idx  (frame_idx)
);

// File: tb/sim_iec_subframe_fmt.sv
module sim_iec_subframe_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        cfg_mode = 1'b0;
    logic [3:0]  cfg_chans = 4'd2;
    logic        seed_load = 1'b0;
    logic [31:0] seed_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int          mfr = 0;
    int          mch = 0;
    int          mcnt = 2;
    logic [31:0] mseed = '0;

    // Pre-formatted vectors: {input word, expected output} (R7)
    localparam logic [63:0] PRE_VEC [0:5] = '{
        {32'hF1234568, 32'h1F123456},
        {32'hA0000004, 32'h0A000000},
        {32'h5ABCDEF2, 32'h05ABCDEF},
        {32'h0000000F, 32'h10000000},
        {32'hFFFFFFF7, 32'h0FFFFFFF},
        {32'h12345678, 32'h11234567}
    };

    always #2 clk = ~clk;

    iec_subframe_fmt u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .cfg_mode  (cfg_mode),
        .cfg_chans (cfg_chans),
        .seed_load (seed_load),
        .seed_data (seed_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pcm_ref(input logic [31:0] s, input int fr, input int ch,
                                            input logic [31:0] seed);
        logic [31:0] cs;
        logic [31:0] w;
        cs = seed;
        cs[23:20] = 4'(ch + 1);
        w = '0;
        w[23:0] = s[23:0];
        w[26] = (fr < 32) ? cs[fr] : 1'b0;
        w[28] = (fr == 0) && (ch == 0);
        w[27] = ^w[26:0];
        return w;
    endfunction

    task automatic push(input logic [31:0] w, input logic [31:0] exp, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1 && out_data === exp, req, out_data, exp);
    endtask

    task automatic model_step();
        mch++;
        if (mch == mcnt) begin
            mch = 0;
            mfr = (mfr == 191) ? 0 : mfr + 1;
        end
    endtask

    task automatic pcm_push(input logic [31:0] s, input string req);
        push(s, pcm_ref(s, mfr, mch, mseed), req);
        model_step();
    endtask

    task automatic pcm_run(input int n, input int base, input string req);
        for (int i = 0; i < n; i++) begin
            logic [31:0] s;
            s = {8'(i * 37) ^ 8'hC3, 24'(i * 7919 + base)};
            pcm_push(s, req);
        end
    endtask

    task automatic do_restart(input logic mode, input logic [3:0] chans);
        @(negedge clk);
        cfg_mode  = mode;
        cfg_chans = chans;
        restart   = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        mfr = 0;
        mch = 0;
        mcnt = (chans < 2) ? 2 : (chans > 8) ? 8 : int'(chans);
    endtask

    task automatic load_seed(input logic [31:0] v);
        @(negedge clk);
        seed_load = 1'b1;
        seed_data = v;
        @(negedge clk);
        seed_load = 1'b0;
        mseed = v;
    endtask

    initial begin
        logic [31:0] held;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R11 reset out_valid", {31'b0, out_valid}, 32'h0);
        chk(in_ready === 1'b1, "R11 reset in_ready", {31'b0, in_ready}, 32'h1);

        // Default after reset: PCM, two channels, zero seed
        pcm_run(4, 11, "R11 reset defaults");

        // Pre-formatted table
        do_restart(1'b1, 4'd2);
        for (int i = 0; i < 6; i++) begin
            push(PRE_VEC[i][63:32], PRE_VEC[i][31:0], "R7 table");
        end

        // Configuration change without restart is ignored
        @(negedge clk);
        cfg_mode  = 1'b0;
        cfg_chans = 4'd5;
        push(32'h12345678, 32'h11234567, "R8 config ignored without restart");

        // PCM, two channels, crossing the 191->0 wrap
        load_seed(32'hA5C3_0F96);
        do_restart(1'b0, 4'd2);
        pcm_run(392, 100, "R1 R2 R3 R5 R6 two channels");

        // Six channels: channel-number patch
        load_seed(32'h3C5A_E187);
        do_restart(1'b0, 4'd6);
        pcm_run(6 * 40, 7, "R4 six channels");

        // Eight channels
        load_seed(32'hFFFF_FFFF);
        do_restart(1'b0, 4'd8);
        pcm_run(8 * 25, 3, "R4 eight channels");

        // Clamping
        load_seed(32'h0000_0000);
        do_restart(1'b0, 4'd1);
        pcm_run(2 * 24, 55, "R9 count below range");
        do_restart(1'b0, 4'd15);
        pcm_run(8 * 24, 77, "R9 count above range");

        // Backpressure
        load_seed(32'h1234_5678);
        do_restart(1'b0, 4'd2);
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_data   = 32'hDE00_0001;
        @(posedge clk);
        @(negedge clk);
        held = pcm_ref(32'hDE00_0001, mfr, mch, mseed);
        model_step();
        chk(out_valid === 1'b1 && out_data === held, "R10 first held", out_data, held);
        in_data = 32'hAD00_0002;
        for (int k = 0; k < 3; k++) begin
            chk(in_ready === 1'b0, "R10 in_ready low while stalled", {31'b0, in_ready}, 32'h0);
            @(posedge clk);
            @(negedge clk);
            chk(out_data === held && out_valid === 1'b1, "R10 held stable", out_data, held);
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        exp = pcm_ref(32'hAD00_0002, mfr, mch, mseed);
        model_step();
        chk(out_valid === 1'b1 && out_data === exp, "R10 next in order", out_data, exp);
        @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R10 no duplicate", {31'b0, out_valid}, 32'h0);

        // Restart flushes a held word
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_data   = 32'h0000_0033;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, "R8 word held before flush", {31'b0, out_valid}, 32'h1);
        restart = 1'b1;
        #1;
        chk(in_ready === 1'b0, "R8 no accept on restart", {31'b0, in_ready}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0;
        mfr = 0;
        mch = 0;
        chk(out_valid === 1'b0, "R8 flushed", {31'b0, out_valid}, 32'h0);
        out_ready = 1'b1;
        exp = pcm_ref(32'h0000_0044, 0, 0, mseed);
        push(32'h0000_0044, exp, "R8 R5 block start after restart");
        chk(out_data[28] === 1'b1, "R5 block flag set", out_data, exp);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule